// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a master-only synchronous serial port. It exchanges words of 4 to 16 bits with one external peripheral and always drives the serial clock itself. Before each transfer, a configuration input selects one of three frame styles:

- An SPI-style full-duplex frame with an active-low select.
- A TI-style frame introduced by a one-clock-wide high frame pulse.
- A MICROWIRE-style half-duplex exchange, in which an 8-bit command goes out and a response word comes back.

Two independent 8-entry word FIFOs buffer the traffic. Words pushed into the transmit FIFO start transfers on their own whenever the port is enabled. Each received word lands right-justified in the receive FIFO, where the surrounding logic pops it. The serial clock comes from the input clock through a prescaler and a bit-rate divider in series. Status outputs report FIFO occupancy, activity and a sticky receive overrun.

Configuration (format, word length, prescale, divide) is meant to be changed only while the port is idle. It is captured when a frame starts.

Top module: `sync_serial_master`

## Requirements
- R1: `sclk` idles low and stays low whenever `busy` is low. Each high and each low half of `sclk` lasts (cfgPrescale+1)*(cfgDivider+1) input clocks.
- R2: The transmit FIFO holds 8 words. A push while it is full is ignored. `txEmpty` is high with no words queued, and `txNotFull` is low with 8 queued.
- R3: With `cfgFormat` 0 (or 3), SPI style:
  - `frameSel` is low from the first bit to the last bit of the frame, and high when idle.
  - Data goes out MSB first on `mosi`, and `mosi` changes only while `sclk` is low.
  - The peripheral's bit on `miso` is taken just before each rising `sclk` edge.
  - Every clock period both sends and receives one bit.
- R4: With `cfgFormat` 1, TI style:
  - One `sclk` period with `frameSel` high and `mosi` low comes first.
  - The data periods follow with `frameSel` low, full duplex as in R3.
  - `frameSel` rests low when idle.
- R5: With `cfgFormat` 2, MICROWIRE style:
  - `frameSel` is low for the whole exchange.
  - The low 8 bits of the transmit word go out MSB first, with nothing received.
  - A response word is then clocked in while `mosi` is held low.
- R6: `cfgLenCode` is the word length minus one, for lengths 4 to 16. Codes 0 to 2 act as a 4-bit word. Only the low bits of a transmit word are sent, and received words are right-justified with zero upper bits.
- R7: A frame starts only when `cfgEnable` is high and the transmit FIFO is non-empty. Otherwise `busy` stays low and queued words wait.
- R8: A received word that finds the receive FIFO full is discarded and sets `rxOverrun`. `rxOverrun` stays set until an `overrunClr` pulse.
- R9: The receive FIFO holds 8 words, returned in arrival order. `rxWord` shows the oldest word, `rxPop` removes it, and the `rxNotEmpty` and `rxFull` flags follow the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Allows frames to start |
| cfgFormat | input | 2 | 0/3 SPI, 1 TI, 2 MICROWIRE |
| cfgLenCode | input | 4 | Word length minus one |
| cfgPrescale | input | 8 | Prescaler terminal count |
| cfgDivider | input | 8 | Bit-rate divider terminal count |
| txPush | input | 1 | Push `txWord` into the transmit FIFO |
| txWord | input | 16 | Word to transmit |
| rxPop | input | 1 | Remove the oldest received word |
| rxWord | output | 16 | Oldest received word |
| overrunClr | input | 1 | Clears `rxOverrun` |
| txEmpty | output | 1 | Transmit FIFO empty |
| txNotFull | output | 1 | Transmit FIFO has space |
| rxNotEmpty | output | 1 | Receive FIFO holds a word |
| rxFull | output | 1 | Receive FIFO full |
| busy | output | 1 | A frame is in progress |
| rxOverrun | output | 1 | Sticky receive overrun |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| frameSel | output | 1 | Select (SPI, MICROWIRE) or frame pulse (TI) |

## Verification
A corrupted phase or slot counter shows up within one serial half period, as an `sclk` pulse of the wrong width or a wrong count of rising edges per frame. A wrong shift alignment or a wrong format latch makes the word the peripheral captures differ from the pushed word at the end of that same frame. A wrong `frameSel` polarity or placement is caught on the first rising `sclk` edge of the frame. FIFO pointer or count faults surface as a wrong `rxWord`, wrong full/empty flags, or a wrong number of frames run from a pre-filled queue.

// File: rtl/sser_pkg.sv
package sser_pkg;

  typedef enum logic [1:0] {
    FMT_SPI = 2'd0,
    FMT_TI  = 2'd1,
    FMT_MW  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_RESP,
    ST_GAP
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // pop tx FIFO into shifter, clear rx shifter
    logic loadCmd;  // load 8-bit command alignment instead of word alignment
    logic sample;   // take miso into rx shifter
    logic shift;    // advance tx shifter
    logic push;     // deliver rx shifter to rx FIFO
  } strobe_t;

endpackage

// File: rtl/sser_fifo.sv
module sser_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sser_ctrl.sv
module sser_ctrl
  import sser_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 8,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [1:0]    fmtIn,
  input  logic [LW-1:0] lenIn,
  input  logic [PW-1:0] pre,
  input  logic [PW-1:0] div,
  input  logic          txEmpty,
  output strobe_t       st,
  output logic [LW-1:0] loadLen,
  output logic          sclk,
  output logic          frameSel,
  output logic          mosiEn,
  output logic          busy
);
  localparam logic [LW-1:0] MIN_LEN  = LW'(3);
  localparam logic [LW-1:0] CMD_LAST = LW'(7);

  state_t state;
  fmt_t fmtQ, effFmt;
  logic phaseHi, tick, start, running, rxPhase;
  logic [LW-1:0] slot, lenQ, effLen, lastSlot;
  logic [PW-1:0] preCnt, divCnt;

  assign effLen = (lenIn < MIN_LEN) ? MIN_LEN : lenIn;
  always_comb begin
    case (fmtIn)
      2'd1:    effFmt = FMT_TI;
      2'd2:    effFmt = FMT_MW;
      default: effFmt = FMT_SPI;
    endcase
  end

  assign running  = (state != ST_IDLE);
  assign start    = (state == ST_IDLE) && enable && !txEmpty;
  assign tick     = running && (preCnt == pre) && (divCnt == div);
  assign lastSlot = (state == ST_XFER && fmtQ == FMT_MW) ? CMD_LAST : lenQ;
  assign rxPhase  = (state == ST_XFER && fmtQ != FMT_MW) || (state == ST_RESP);

  // prescaler then divider; both restart at every frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (!running) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preCnt == pre) begin
      preCnt <= '0;
      divCnt <= (divCnt == div) ? '0 : divCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phaseHi <= 1'b0;
      slot    <= '0;
      fmtQ    <= FMT_SPI;
      lenQ    <= LW'(7);
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          fmtQ    <= effFmt;
          lenQ    <= effLen;
          phaseHi <= 1'b0;
          slot    <= '0;
          state   <= (effFmt == FMT_TI) ? ST_LEAD : ST_XFER;
        end
        ST_LEAD: if (tick) begin
          phaseHi <= !phaseHi;
          if (phaseHi) state <= ST_XFER;
        end
        ST_XFER, ST_RESP: if (tick) begin
          phaseHi <= !phaseHi;
          if (phaseHi) begin
            if (slot == lastSlot) begin
              slot  <= '0;
              state <= (state == ST_XFER && fmtQ == FMT_MW) ? ST_RESP : ST_GAP;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_GAP: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    st.load    = start;
    st.loadCmd = (effFmt == FMT_MW);
    st.sample  = tick && !phaseHi && rxPhase;
    st.shift   = tick && phaseHi && (state == ST_XFER);
    st.push    = tick && phaseHi && rxPhase && (slot == lastSlot);
  end

  assign loadLen  = effLen;
  assign sclk     = phaseHi && (state == ST_LEAD || state == ST_XFER || state == ST_RESP);
  assign frameSel = (fmtQ == FMT_TI) ? (state == ST_LEAD)
                                     : !(state == ST_XFER || state == ST_RESP);
  assign mosiEn   = (state == ST_XFER);
  assign busy     = running;
endmodule

// File: rtl/sser_datapath.sv
module sser_datapath
  import sser_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [LW-1:0] loadLen,
  input  logic          txPush,
  input  logic [W-1:0]  txWord,
  input  logic          rxPop,
  input  logic          overrunClr,
  input  logic          miso,
  output logic          mosiBit,
  output logic [W-1:0]  rxWord,
  output logic          txEmpty,
  output logic          txFull,
  output logic          rxEmpty,
  output logic          rxFull,
  output logic          rxOverrun
);
  logic [W-1:0] txHead, txShift, rxShift;

  sser_fifo #(.W(W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pop(st.load), .din(txWord),
    .head(txHead), .empty(txEmpty), .full(txFull)
  );

  sser_fifo #(.W(W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .push(st.push), .pop(rxPop), .din(rxShift),
    .head(rxWord), .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (st.load)
        txShift <= st.loadCmd ? {txHead[7:0], {(W-8){1'b0}}}
                              : txHead << (LW'(W-1) - loadLen);
      else if (st.shift)
        txShift <= {txShift[W-2:0], 1'b0};
      if (st.load)        rxShift <= '0;
      else if (st.sample) rxShift <= {rxShift[W-2:0], miso};
      if (st.push && rxFull) rxOverrun <= 1'b1;
      else if (overrunClr)   rxOverrun <= 1'b0;
    end
  end

  assign mosiBit = txShift[W-1];
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import sser_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int PW    = 8,
  localparam int LW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgEnable,
  input  logic [1:0]    cfgFormat,
  input  logic [LW-1:0] cfgLenCode,
  input  logic [PW-1:0] cfgPrescale,
  input  logic [PW-1:0] cfgDivider,
  input  logic          txPush,
  input  logic [W-1:0]  txWord,
  input  logic          rxPop,
  output logic [W-1:0]  rxWord,
  input  logic          overrunClr,
  output logic          txEmpty,
  output logic          txNotFull,
  output logic          rxNotEmpty,
  output logic          rxFull,
  output logic          busy,
  output logic          rxOverrun,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          frameSel
);
  strobe_t st;
  logic [LW-1:0] loadLen;
  logic mosiEn, mosiBit, txFull, rxEmpty;

  sser_ctrl #(.W(W), .PW(PW)) ctrl (
    .clk(clk), .rstN(rstN), .enable(cfgEnable), .fmtIn(cfgFormat),
    .lenIn(cfgLenCode), .pre(cfgPrescale), .div(cfgDivider),
    .txEmpty(txEmpty), .st(st), .loadLen(loadLen), .sclk(sclk),
    .frameSel(frameSel), .mosiEn(mosiEn), .busy(busy)
  );

  sser_datapath #(.W(W), .DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .st(st), .loadLen(loadLen), .txPush(txPush),
    .txWord(txWord), .rxPop(rxPop), .overrunClr(overrunClr), .miso(miso),
    .mosiBit(mosiBit), .rxWord(rxWord), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxOverrun(rxOverrun)
  );

  assign txNotFull  = !txFull;
  assign rxNotEmpty = !rxEmpty;
  assign mosi       = mosiEn && mosiBit;
endmodule

// File: rtl/sync_serial_master_chk.sv
module sync_serial_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgEnable,
  input logic [1:0] cfgFormat,
  input logic       txEmpty,
  input logic       txNotFull,
  input logic       rxNotEmpty,
  input logic       rxFull,
  input logic       busy,
  input logic       rxOverrun,
  input logic       overrunClr,
  input logic       sclk,
  input logic       mosi,
  input logic       frameSel
);
  assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  assert_tx_flags_R2: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txNotFull);

  assert_spi_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclk && cfgFormat == 2'd0) |-> !frameSel);

  assert_ti_lead_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclk && frameSel && cfgFormat == 2'd1) |-> !mosi);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (!cfgEnable || txEmpty)) |=> !busy);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !overrunClr) |=> rxOverrun);

  assert_rx_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxNotEmpty);
endmodule

bind sync_serial_master sync_serial_master_chk u_chk (.*);

// File: tb/sync_serial_master_test.sv
module sync_serial_master_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0;
  logic [1:0] cfgFormat = 2'd0;
  logic [3:0] cfgLenCode = 4'd7;
  logic [7:0] cfgPrescale = 8'd0;
  logic [7:0] cfgDivider = 8'd0;
  logic txPush = 1'b0;
  logic [15:0] txWord = '0;
  logic rxPop = 1'b0;
  logic overrunClr = 1'b0;
  logic miso = 1'b0;
  logic [15:0] rxWord;
  logic txEmpty, txNotFull, rxNotEmpty, rxFull, busy, rxOverrun, sclk, mosi, frameSel;

  sync_serial_master uut (.*);

  always #10 clk = !clk;  // 50 MHz

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int curFmt = 0;
  int curN = 8;
  int halfLen = 1;
  int frameCnt = 0;
  logic [15:0] slvQ[$];
  logic [15:0] txExpQ[$];
  logic [15:0] rxExpQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input int f);
    return (f == 1) ? "R4" : (f == 2) ? "R5" : "R3";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      nChecks++;
      $display("FAIL R7 watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // behavioural peripheral and frame monitor
  int riseCnt = 0, rxIdx = 0, hiCnt = 0, expRises;
  logic [15:0] cap = '0, curSlv = '0, expTx;
  logic prevSclk = 1'b0, prevBusy = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!prevBusy && busy) begin
        riseCnt = 0; rxIdx = 0; cap = '0;
        curSlv = (slvQ.size() > 0) ? slvQ.pop_front() : 16'h0;
      end
      if (!prevSclk && sclk) begin
        if (curFmt == 1 && riseCnt == 0) begin
          check(frameSel == 1'b1 && mosi == 1'b0, "R4", {frameSel, mosi}, 2'b10);
        end else if (curFmt == 2 && riseCnt >= 8) begin
          check(mosi == 1'b0 && frameSel == 1'b0, "R5", {frameSel, mosi}, 2'b00);
          rxIdx++;
        end else begin
          cap = {cap[14:0], mosi};
          check(frameSel == 1'b0, tagOf(curFmt), frameSel, 0);
          if (curFmt != 2) rxIdx++;
        end
        riseCnt++;
        hiCnt = 0;
      end
      if (sclk) hiCnt++;
      if (prevSclk && !sclk) check(hiCnt == halfLen, "R1", hiCnt, halfLen);
      if (!busy) check(!sclk && !mosi, "R1", {sclk, mosi}, 0);
      if (prevBusy && !busy) begin
        expRises = (curFmt == 1) ? curN + 1 : (curFmt == 2) ? curN + 8 : curN;
        check(riseCnt == expRises, tagOf(curFmt), riseCnt, expRises);
        expTx = (txExpQ.size() > 0) ? txExpQ.pop_front() : 16'hDEAD;
        check(cap == expTx, tagOf(curFmt), cap, expTx);
        check(frameSel == (curFmt != 1), tagOf(curFmt), frameSel, (curFmt != 1));
        frameCnt++;
      end
      miso = (rxIdx < curN) ? curSlv[curN - 1 - rxIdx] : 1'b0;
      prevSclk = sclk;
      prevBusy = busy;
    end
  end

  task automatic setCfg(input int f, input int code, input int p, input int d);
    @(negedge clk);
    cfgFormat = 2'(f);
    cfgLenCode = 4'(code);
    cfgPrescale = 8'(p);
    cfgDivider = 8'(d);
    curFmt = (f == 3) ? 0 : f;
    curN = ((code < 3) ? 3 : code) + 1;
    halfLen = (p + 1) * (d + 1);
  endtask

  task automatic pushRaw(input logic [15:0] w);
    @(negedge clk);
    txWord = w;
    txPush = 1'b1;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] tx, input logic [15:0] slv);
    logic [15:0] mask;
    mask = 16'((32'h1 << curN) - 1);
    slvQ.push_back(slv);
    txExpQ.push_back((curFmt == 2) ? (tx & 16'h00FF) : (tx & mask));
    rxExpQ.push_back(slv & mask);
    pushRaw(tx);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(txEmpty && !busy));
    repeat (3) @(negedge clk);
  endtask

  task automatic popAll(input string req);
    logic [15:0] e;
    while (rxExpQ.size() > 0) begin
      e = rxExpQ.pop_front();
      @(negedge clk);
      check(rxNotEmpty == 1'b1, "R9", rxNotEmpty, 1);
      check(rxWord == e, req, rxWord, e);
      rxPop = 1'b1;
      @(negedge clk);
      rxPop = 1'b0;
    end
    @(negedge clk);
    check(rxNotEmpty == 1'b0, "R9", rxNotEmpty, 0);
  endtask

  int startFrames;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(txEmpty && txNotFull, "R2", {txEmpty, txNotFull}, 2'b11);
    check(!rxNotEmpty && !rxFull && !rxOverrun, "R9", {rxNotEmpty, rxFull, rxOverrun}, 0);
    check(!busy && !sclk && frameSel, "R1", {busy, sclk, frameSel}, 3'b001);

    // R7: disabled port holds queued word
    setCfg(0, 7, 1, 0);
    sendWord(16'h00A5, 16'h0055);
    repeat (40) @(negedge clk);
    check(!busy && !txEmpty, "R7", {busy, txEmpty}, 2'b00);
    cfgEnable = 1'b1;
    sendWord(16'h003C, 16'h00C3);
    sendWord(16'h0081, 16'h007E);
    waitIdle();
    popAll("R3");

    // SPI full 16-bit words
    setCfg(0, 15, 0, 2);
    sendWord(16'hBEEF, 16'h1357);
    sendWord(16'h8001, 16'hFFFE);
    waitIdle();
    popAll("R3");

    // R6: short codes act as 4-bit words
    setCfg(3, 1, 0, 0);
    sendWord(16'h1234, 16'hFFFF);
    waitIdle();
    popAll("R6");

    // TI style, 12 bits
    setCfg(1, 11, 1, 1);
    sendWord(16'h0A5C, 16'h0F0F);
    sendWord(16'hF3C1, 16'h0801);
    waitIdle();
    popAll("R4");

    // MICROWIRE command + 10-bit response
    setCfg(2, 9, 2, 0);
    sendWord(16'hABC5, 16'h02AB);
    waitIdle();
    popAll("R5");

    // R2 / R8 / R9: fill both FIFOs, then overrun
    cfgEnable = 1'b0;
    setCfg(0, 3, 0, 0);
    for (int i = 0; i < 8; i++) sendWord(16'(i + 1), 16'(15 - i));
    @(negedge clk);
    check(txNotFull == 1'b0, "R2", txNotFull, 0);
    pushRaw(16'h000F);  // ignored, FIFO full
    startFrames = frameCnt;
    cfgEnable = 1'b1;
    waitIdle();
    check(frameCnt - startFrames == 8, "R2", frameCnt - startFrames, 8);
    check(rxFull == 1'b1, "R9", rxFull, 1);
    check(rxOverrun == 1'b0, "R8", rxOverrun, 0);
    slvQ.push_back(16'h0009);
    txExpQ.push_back(16'h0003);
    pushRaw(16'h0003);
    waitIdle();
    check(rxOverrun == 1'b1, "R8", rxOverrun, 1);
    popAll("R8");
    @(negedge clk);
    check(rxOverrun == 1'b1, "R8", rxOverrun, 1);
    overrunClr = 1'b1;
    @(negedge clk);
    overrunClr = 1'b0;
    @(negedge clk);
    check(rxOverrun == 1'b0, "R8", rxOverrun, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule